// File: doc/BRIEF.md
# Single-Channel Memory/Peripheral DMA Engine

This block is one DMA channel. It copies a run of 1-, 2- or 4-byte units between a region of memory and a peripheral data register, acting as master on a simple request/grant bus. Software programs a small register file: a memory current address, a memory end address, a device address, a control word, an activate bit, a status register and an enable register. The channel has no byte counter. It moves the memory current address forward after every unit and finishes when that address reaches the end address. While the transfer is not finished, the difference between the two addresses is readable as the number of bytes still to move.

Every unit is a read from the source followed by a write to the destination. One control bit picks the direction. Two further bits decide whether the memory address and the device address advance. The channel can run in one of two pacing modes. In hardware-paced mode it waits for a pulse on one selected peripheral request line before each unit. In software-paced mode it moves units back to back. Each mode has its own run bit, and a pacing-select bit decides which run bit starts the channel. Software can abort a transfer or halt it, and both take effect at the next unit boundary. A bus error ends the transfer. Four status flags, each under its own enable, drive a single interrupt line.

Top module: `dmac_channel`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `busy` (control bit 7) reads 0. `irq` and `m_req` are low.
- R2: Register offsets on `cfg_addr` are: 0 memory current, 1 memory end, 2 device address, 3 control, 4 activate (bit 0), 5 status, 6 interrupt enable, 7 remaining bytes (read-only). When control bit 2 is 1, each unit reads at the memory current address and writes to the device address. When control bit 2 is 0, each unit reads at the device address and writes to the memory current address.
- R3: Control bits 10:8 give the unit size. The values 1, 2 and 4 are used as given, and any other value means 1. `m_size` carries 0, 1 or 2 for 1, 2 or 4 bytes. After each completed unit, the memory address advances by the unit size when control bit 3 is 1. The device address advances by the unit size when control bit 4 is 1. When control bit 4 is 0, every unit uses the same device address.
- R4: The transfer ends on the unit after which the memory current address is greater than or equal to the end address. At that point status bit 2 (done) is set and busy drops. Offset 7 reads end minus current when end is greater than current, and 0 otherwise.
- R5: A start with the memory current address already greater than or equal to the end address sets done at once and makes no bus access.
- R6: A start is a rising edge of (activate AND the selected run bit). Control bit 5 = 0 selects hardware pacing with run bit 0. Control bit 5 = 1 selects software pacing with run bit 1. The run bit of the other mode has no effect. In hardware pacing, each unit waits for a high level on `hw_req[sel]`, where sel is control bits 13:11. Pulses on other request lines have no effect.
- R7: In hardware pacing, a high level on the selected request line while a unit is in flight sets status bit 1 (overflow). The last unit of a hardware-paced transfer sets status bit 3 (paced end) together with done.
- R8: Writing control bit 6 (abort) while busy, or clearing activate or the selected run bit, stops the channel after the unit in flight. Busy then drops, done stays clear, and abort reads back 0.
- R9: An `m_err` on a granted access sets status bit 0 (bus error), drops busy and leaves the addresses where they were before the failing unit.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R11: `irq` is high exactly when some status bit and its matching enable bit (offset 6, bits 3:0) are both 1.
- R12: Once `m_req` is raised, it stays high, and `m_addr` and `m_we` stay stable, until the cycle in which `m_gnt` is high. `m_req` is only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| hw_req | input | NREQ | Peripheral pacing request lines |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Access is a write |
| m_addr | output | AW | Access byte address |
| m_size | output | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| m_wdata | output | 32 | Write data, low bytes significant |
| m_gnt | input | 1 | Access accepted and completed this cycle |
| m_rdata | input | 32 | Read data, valid with the grant |
| m_err | input | 1 | Error response, valid with the grant |
| irq | output | 1 | Interrupt request |

## Verification
Two activities can land on the same clock edge: the hardware setting a status flag, and a software write-one-to-clear of that same status register. The bench sets up this collision on purpose. It first leaves done set from an earlier transfer. It then starts a new transfer and holds back the grant for the final write. On a single falling edge it both releases that grant and drives a write of all ones to the status offset. The check passes only if done still reads 1 afterwards. A second overlap, a pacing request that arrives while a unit is stalled on the bus, is judged by the overflow flag.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        RA_MCUR   = 3'd0,
        RA_MEND   = 3'd1,
        RA_DADDR  = 3'd2,
        RA_CTRL   = 3'd3,
        RA_ACT    = 3'd4,
        RA_STAT   = 3'd5,
        RA_IEN    = 3'd6,
        RA_REMAIN = 3'd7
    } reg_addr_e;

    // stored control fields; bit 7 of the control word is the live busy flag
    typedef struct packed {
        logic [2:0] psel;     // 13:11
        logic [2:0] usize;    // 10:8
        logic       abort;    // 6
        logic       sw_pace;  // 5
        logic       inc_dev;  // 4
        logic       inc_mem;  // 3
        logic       m2d;      // 2
        logic       sw_run;   // 1
        logic       hw_run;   // 0
    } ctrl_t;

    typedef struct packed {
        logic pterm;  // 3
        logic done;   // 2
        logic ovf;    // 1
        logic berr;   // 0
    } flags_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_RD   = 2'd2,
        XS_WR   = 2'd3
    } xfer_st_e;

    function automatic logic [2:0] unit_bytes(input logic [2:0] f);
        case (f)
            3'd2:    return 3'd2;
            3'd4:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] size_code(input logic [2:0] f);
        case (f)
            3'd2:    return 2'd1;
            3'd4:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.psel    = w[13:11];
        c.usize   = w[10:8];
        c.abort   = w[6];
        c.sw_pace = w[5];
        c.inc_dev = w[4];
        c.inc_mem = w[3];
        c.m2d     = w[2];
        c.sw_run  = w[1];
        c.hw_run  = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c, input logic busy);
        return {18'd0, c.psel, c.usize, busy, c.abort, c.sw_pace,
                c.inc_dev, c.inc_mem, c.m2d, c.sw_run, c.hw_run};
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          busy,
    input  logic          adv,
    input  logic [AW-1:0] mcur_nxt,
    input  logic [AW-1:0] daddr_nxt,
    input  flags_t        flag_set,
    input  logic          stop,
    output logic [AW-1:0] mcur,
    output logic [AW-1:0] mend,
    output logic [AW-1:0] daddr,
    output ctrl_t         ctrl,
    output logic          act,
    output flags_t        ists,
    output flags_t        ien,
    output logic          irq
);

    logic   wr_mcur, wr_mend, wr_daddr, wr_ctrl, wr_act, wr_stat, wr_ien;
    ctrl_t  ctrl_wr, ctrl_nxt;
    flags_t clr_mask;
    logic [AW-1:0] remain;

    always_comb begin
        wr_mcur  = cfg_we && (cfg_addr == RA_MCUR);
        wr_mend  = cfg_we && (cfg_addr == RA_MEND);
        wr_daddr = cfg_we && (cfg_addr == RA_DADDR);
        wr_ctrl  = cfg_we && (cfg_addr == RA_CTRL);
        wr_act   = cfg_we && (cfg_addr == RA_ACT);
        wr_stat  = cfg_we && (cfg_addr == RA_STAT);
        wr_ien   = cfg_we && (cfg_addr == RA_IEN);
        ctrl_wr  = ctrl_unpack(cfg_wdata);
        clr_mask = wr_stat ? flags_t'(cfg_wdata[3:0]) : '0;
    end

    // abort only lives while a transfer is busy and is dropped at the stop point
    always_comb begin
        ctrl_nxt       = wr_ctrl ? ctrl_wr : ctrl;
        ctrl_nxt.abort = busy && !stop && (wr_ctrl ? ctrl_wr.abort : ctrl.abort);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcur  <= '0;
            mend  <= '0;
            daddr <= '0;
            ctrl  <= '0;
            act   <= 1'b0;
            ists  <= '0;
            ien   <= '0;
        end else begin
            if (adv)           mcur <= mcur_nxt;
            else if (wr_mcur)  mcur <= cfg_wdata[AW-1:0];
            if (wr_mend)       mend <= cfg_wdata[AW-1:0];
            if (adv)           daddr <= daddr_nxt;
            else if (wr_daddr) daddr <= cfg_wdata[AW-1:0];
            ctrl <= ctrl_nxt;
            if (wr_act)        act <= cfg_wdata[0];
            if (wr_ien)        ien <= flags_t'(cfg_wdata[3:0]);
            ists <= (ists & ~clr_mask) | flag_set;
        end
    end

    assign remain = (mend > mcur) ? (mend - mcur) : '0;
    assign irq    = |(ists & ien);

    always_comb begin
        case (reg_addr_e'(cfg_addr))
            RA_MCUR:   cfg_rdata = 32'(mcur);
            RA_MEND:   cfg_rdata = 32'(mend);
            RA_DADDR:  cfg_rdata = 32'(daddr);
            RA_CTRL:   cfg_rdata = ctrl_pack(ctrl, busy);
            RA_ACT:    cfg_rdata = {31'd0, act};
            RA_STAT:   cfg_rdata = {28'd0, ists};
            RA_IEN:    cfg_rdata = {28'd0, ien};
            default:   cfg_rdata = 32'(remain);
        endcase
    end

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic            act,
    input  logic [AW-1:0]   mcur,
    input  logic [AW-1:0]   mend,
    input  logic [AW-1:0]   daddr,
    input  logic [NREQ-1:0] hw_req,
    output logic            m_req,
    output logic            m_we,
    output logic [AW-1:0]   m_addr,
    output logic [1:0]      m_size,
    output logic [31:0]     m_wdata,
    input  logic            m_gnt,
    input  logic [31:0]     m_rdata,
    input  logic            m_err,
    output logic            busy,
    output logic            adv,
    output logic [AW-1:0]   mcur_nxt,
    output logic [AW-1:0]   daddr_nxt,
    output flags_t          flag_set,
    output logic            stop
);

    localparam int PSW  = 3;
    localparam int NSEL = 1 << PSW;

    xfer_st_e      state;
    logic [31:0]   dbuf;
    logic          go, go_q, start, empty, last, in_unit, ack, ok, pace_hit;
    logic [2:0]    ub;
    logic [NSEL-1:0] req_pad;

    generate
        if (NREQ < NSEL) begin : g_pad
            assign req_pad = {{(NSEL-NREQ){1'b0}}, hw_req};
        end else begin : g_full
            assign req_pad = hw_req[NSEL-1:0];
        end
    endgenerate

    always_comb begin
        ub        = unit_bytes(ctrl.usize);
        mcur_nxt  = mcur  + (ctrl.inc_mem ? AW'(ub) : '0);
        daddr_nxt = daddr + (ctrl.inc_dev ? AW'(ub) : '0);
        go        = act && (ctrl.sw_pace ? ctrl.sw_run : ctrl.hw_run);
        start     = go && !go_q && (state == XS_IDLE);
        empty     = mcur >= mend;
        last      = mcur_nxt >= mend;
        pace_hit  = req_pad[ctrl.psel];
        in_unit   = (state == XS_RD) || (state == XS_WR);
        ack       = in_unit && m_gnt;
        ok        = ack && !m_err;
        adv       = (state == XS_WR) && ok;
        stop      = (state == XS_WAIT) && (ctrl.abort || !go);
        busy      = state != XS_IDLE;

        flag_set.done  = (start && empty) || (adv && last);
        flag_set.pterm = adv && last && !ctrl.sw_pace;
        flag_set.berr  = ack && m_err;
        flag_set.ovf   = in_unit && !ctrl.sw_pace && pace_hit;

        m_req   = in_unit;
        m_we    = state == XS_WR;
        m_size  = size_code(ctrl.usize);
        m_wdata = m_we ? dbuf : '0;
        if (state == XS_RD)      m_addr = ctrl.m2d ? mcur  : daddr;
        else if (state == XS_WR) m_addr = ctrl.m2d ? daddr : mcur;
        else                     m_addr = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XS_IDLE;
            go_q  <= 1'b0;
            dbuf  <= '0;
        end else begin
            go_q <= go;
            case (state)
                XS_IDLE: if (start && !empty) state <= XS_WAIT;
                XS_WAIT: begin
                    if (stop)                             state <= XS_IDLE;
                    else if (ctrl.sw_pace || pace_hit)    state <= XS_RD;
                end
                XS_RD: if (ack) begin
                    if (m_err) state <= XS_IDLE;
                    else begin
                        dbuf  <= m_rdata;
                        state <= XS_WR;
                    end
                end
                default: if (ack) state <= (m_err || last) ? XS_IDLE : XS_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic [NREQ-1:0] hw_req,
    output logic            m_req,
    output logic            m_we,
    output logic [AW-1:0]   m_addr,
    output logic [1:0]      m_size,
    output logic [31:0]     m_wdata,
    input  logic            m_gnt,
    input  logic [31:0]     m_rdata,
    input  logic            m_err,
    output logic            irq
);

    logic          busy, adv, stop, act_q;
    logic [AW-1:0] mcur, mend, daddr, mcur_nxt, daddr_nxt;
    ctrl_t         ctrl_q;
    flags_t        flag_set, ists_q, ien_q;

    dmac_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .adv       (adv),
        .mcur_nxt  (mcur_nxt),
        .daddr_nxt (daddr_nxt),
        .flag_set  (flag_set),
        .stop      (stop),
        .mcur      (mcur),
        .mend      (mend),
        .daddr     (daddr),
        .ctrl      (ctrl_q),
        .act       (act_q),
        .ists      (ists_q),
        .ien       (ien_q),
        .irq       (irq)
    );

    dmac_engine #(.AW(AW), .NREQ(NREQ)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .act       (act_q),
        .mcur      (mcur),
        .mend      (mend),
        .daddr     (daddr),
        .hw_req    (hw_req),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_size    (m_size),
        .m_wdata   (m_wdata),
        .m_gnt     (m_gnt),
        .m_rdata   (m_rdata),
        .m_err     (m_err),
        .busy      (busy),
        .adv       (adv),
        .mcur_nxt  (mcur_nxt),
        .daddr_nxt (daddr_nxt),
        .flag_set  (flag_set),
        .stop      (stop)
    );

endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [2:0]    cfg_addr,
    input logic          m_req,
    input logic          m_we,
    input logic          m_gnt,
    input logic          m_err,
    input logic [AW-1:0] m_addr,
    input logic [1:0]    m_size,
    input logic          busy,
    input logic [AW-1:0] mcur,
    input logic [2:0]    usize,
    input logic          inc_mem,
    input flags_t        ists,
    input flags_t        ien,
    input logic          irq
);

    logic [AW-1:0] ub_c;
    assign ub_c = AW'(unit_bytes(usize));

    // R12: requests only while busy
    p_req_needs_busy_r12: assert property (@(posedge clk) disable iff (rst)
        m_req |-> busy);

    // R12: request held with stable address and direction until granted
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    // R3: legal size code only
    p_size_legal_r3: assert property (@(posedge clk) disable iff (rst)
        m_req |-> (m_size != 2'd3));

    // R3: a completed write advances memory address by the unit size
    p_mem_adv_r3: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we && m_gnt && !m_err && inc_mem) |=> (mcur == $past(mcur) + $past(ub_c)));

    // R9: an error response stops the channel and flags it
    p_err_halts_r9: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_gnt && m_err) |=> (!busy && ists.berr));

    // R9: no address advance for the failing unit
    p_err_no_adv_r9: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_gnt && m_err && !(cfg_we && cfg_addr == 3'd0)) |=> $stable(mcur));

    // R11: nothing enabled means no interrupt
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (ien == 4'd0) |-> !irq);

endmodule

bind dmac_channel dmac_channel_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_gnt    (m_gnt),
    .m_err    (m_err),
    .m_addr   (m_addr),
    .m_size   (m_size),
    .busy     (busy),
    .mcur     (mcur),
    .usize    (ctrl_q.usize),
    .inc_mem  (ctrl_q.inc_mem),
    .ists     (ists_q),
    .ien      (ien_q),
    .irq      (irq)
);

// File: tb/dmac_channel_bench.sv
module dmac_channel_bench;

    localparam int AW = 32;
    localparam int NREQ = 4;
    localparam logic [31:0] HW_RUN = 32'h1, SW_RUN = 32'h2, M2D = 32'h4, INCM = 32'h8,
                            INCD = 32'h10, SWP = 32'h20, ABRT = 32'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NREQ-1:0] hw_req = '0;
    logic m_req, m_we, m_gnt, m_err, irq;
    logic [AW-1:0] m_addr;
    logic [1:0] m_size;
    logic [31:0] m_wdata, m_rdata;

    logic gnt_hold = 1'b0, hold_wr = 1'b0, stall_mode = 1'b0, err_en = 1'b0;
    logic [7:0] err_addr = '0;
    logic [7:0] mem [0:255];
    int unsigned cyc = 0;
    int log_n = 0;
    logic [31:0] log_addr [0:255];
    logic        log_we   [0:255];
    logic [1:0]  log_sz   [0:255];
    int total = 0, fails = 0;
    logic [7:0] a8;

    always #2 clk = ~clk;

    dmac_channel #(.AW(AW), .NREQ(NREQ)) u_dmac_channel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hw_req(hw_req), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_size(m_size), .m_wdata(m_wdata), .m_gnt(m_gnt), .m_rdata(m_rdata), .m_err(m_err),
        .irq(irq)
    );

    // bus slave model
    assign a8 = m_addr[7:0];
    assign m_gnt = m_req && !gnt_hold && !(hold_wr && m_we) && (!stall_mode || cyc[0]);
    assign m_err = m_req && err_en && (a8 == err_addr);
    assign m_rdata = {mem[8'(a8+3)], mem[8'(a8+2)], mem[8'(a8+1)], mem[a8]};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (m_req && m_gnt) begin
            log_addr[log_n[7:0]] <= m_addr;
            log_we[log_n[7:0]]   <= m_we;
            log_sz[log_n[7:0]]   <= m_size;
            log_n <= log_n + 1;
            if (m_we && !m_err)
                for (int b = 0; b < (1 << m_size); b++)
                    mem[8'(a8 + b)] <= m_wdata[8*b +: 8];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic setup(input logic [31:0] mc, input logic [31:0] me, input logic [31:0] da);
        wr(3'd3, 32'h0);
        wr(3'd0, mc);
        wr(3'd1, me);
        wr(3'd2, da);
        wr(3'd4, 32'h1);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            rd(3'd3, v);
            if (!v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        hw_req[line] = 1'b1;
        @(negedge clk);
        hw_req[line] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reg %0d after reset", a), v, 32'h0);
        end
        check("R1 irq after reset", {31'd0, irq}, 32'h0);
        check("R1 m_req after reset", {31'd0, m_req}, 32'h0);
    endtask

    task automatic t_sw_m2d();
        logic [31:0] v;
        int base;
        for (int i = 0; i < 8; i++) mem[8'(8'h10 + i)] = 8'(8'h11 + i);
        setup(32'h10, 32'h18, 32'h40);
        base = log_n;
        wr(3'd3, M2D | INCM | SWP | (32'd4 << 8) | SW_RUN);
        wait_idle();
        check("R2 access count m2d", 32'(log_n - base), 32'd4);
        check("R2 first read at memory", log_addr[8'(base)], 32'h10);
        check("R2 first read is read", {31'd0, log_we[8'(base)]}, 32'h0);
        check("R2 write to device", log_addr[8'(base+1)], 32'h40);
        check("R3 second read advanced by 4", log_addr[8'(base+2)], 32'h14);
        check("R3 device address fixed", log_addr[8'(base+3)], 32'h40);
        check("R3 size code for 4 bytes", {30'd0, log_sz[8'(base)]}, 32'd2);
        check("R2 device data", {mem[8'h43], mem[8'h42], mem[8'h41], mem[8'h40]}, 32'h18171615);
        rd(3'd5, v); check("R4 done flag", v, 32'h4);
        rd(3'd0, v); check("R4 current reached end", v, 32'h18);
        rd(3'd7, v); check("R4 remaining zero", v, 32'h0);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_d2m();
        logic [31:0] v;
        int base;
        for (int i = 0; i < 6; i++) mem[8'(8'h60 + i)] = 8'(8'hA0 + i);
        setup(32'h80, 32'h86, 32'h60);
        stall_mode = 1'b1;
        base = log_n;
        wr(3'd3, INCM | INCD | SWP | (32'd2 << 8) | SW_RUN);
        wait_idle();
        stall_mode = 1'b0;
        check("R2 access count d2m", 32'(log_n - base), 32'd6);
        check("R2 d2m reads device", log_addr[8'(base)], 32'h60);
        check("R2 d2m writes memory", log_addr[8'(base+1)], 32'h80);
        check("R3 size code for 2 bytes", {30'd0, log_sz[8'(base)]}, 32'd1);
        check("R2 d2m data", {mem[8'h85], mem[8'h84], mem[8'h83], mem[8'h82]}, 32'hA5A4A3A2);
        rd(3'd0, v); check("R3 memory advanced by 2s", v, 32'h86);
        rd(3'd2, v); check("R3 device advanced by 2s", v, 32'h66);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_size_default();
        logic [31:0] v;
        int base;
        setup(32'h30, 32'h32, 32'h50);
        base = log_n;
        wr(3'd3, M2D | INCM | SWP | (32'd3 << 8) | SW_RUN);
        wait_idle();
        check("R3 unsupported size acts as 1 (count)", 32'(log_n - base), 32'd4);
        check("R3 unsupported size code", {30'd0, log_sz[8'(base)]}, 32'd0);
        rd(3'd0, v); check("R3 advanced by 1", v, 32'h32);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        int base;
        setup(32'h20, 32'h20, 32'h50);
        base = log_n;
        wr(3'd3, M2D | INCM | SWP | (32'd1 << 8) | SW_RUN);
        wait_idle();
        check("R5 equal addresses no access", 32'(log_n - base), 32'd0);
        rd(3'd5, v); check("R5 equal addresses done", v, 32'h4);
        wr(3'd5, 32'hF);
        setup(32'h28, 32'h20, 32'h50);
        wr(3'd3, M2D | INCM | SWP | (32'd1 << 8) | SW_RUN);
        wait_idle();
        check("R5 current past end no access", 32'(log_n - base), 32'd0);
        rd(3'd5, v); check("R5 current past end done", v, 32'h4);
        rd(3'd7, v); check("R4 remaining zero when past end", v, 32'h0);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_hw();
        logic [31:0] v;
        int base;
        logic [31:0] cw;
        cw = M2D | INCM | (32'd1 << 8) | (32'd2 << 11);
        setup(32'h90, 32'h94, 32'h70);
        base = log_n;
        wr(3'd3, cw | SW_RUN);
        repeat (8) @(negedge clk);
        rd(3'd3, v); check("R6 other run bit ignored (busy)", {31'd0, v[7]}, 32'h0);
        wr(3'd3, cw | HW_RUN);
        repeat (6) @(negedge clk);
        rd(3'd3, v); check("R6 busy while waiting", {31'd0, v[7]}, 32'h1);
        check("R6 no access before request", 32'(log_n - base), 32'd0);
        pulse(1);
        repeat (6) @(negedge clk);
        check("R6 other request line ignored", 32'(log_n - base), 32'd0);
        pulse(2);
        repeat (6) @(negedge clk);
        check("R6 one unit per request", 32'(log_n - base), 32'd2);
        rd(3'd7, v); check("R4 remaining mid transfer", v, 32'h3);
        for (int k = 0; k < 3; k++) begin
            pulse(2);
            repeat (6) @(negedge clk);
        end
        wait_idle();
        check("R6 paced access count", 32'(log_n - base), 32'd8);
        rd(3'd5, v); check("R7 paced end with done", v, 32'hC);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_ovf();
        logic [31:0] v;
        setup(32'h94, 32'h96, 32'h70);
        gnt_hold = 1'b1;
        wr(3'd3, M2D | INCM | (32'd1 << 8) | (32'd2 << 11) | HW_RUN);
        repeat (3) @(negedge clk);
        pulse(2);
        repeat (3) @(negedge clk);
        rd(3'd5, v); check("R7 no overflow on accepted request", v, 32'h0);
        pulse(2);
        @(negedge clk);
        rd(3'd5, v); check("R7 overflow on request in flight", v, 32'h2);
        gnt_hold = 1'b0;
        repeat (5) @(negedge clk);
        pulse(2);
        wait_idle();
        rd(3'd5, v); check("R7 flags after paced end", v, 32'hE);
        wr(3'd5, 32'hF);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        logic [31:0] cw;
        cw = M2D | INCM | SWP | (32'd4 << 8) | SW_RUN;
        setup(32'hA0, 32'hB0, 32'h50);
        gnt_hold = 1'b1;
        wr(3'd3, cw);
        repeat (4) @(negedge clk);
        wr(3'd3, cw | ABRT);
        gnt_hold = 1'b0;
        wait_idle();
        rd(3'd0, v); check("R8 abort after unit in flight", v, 32'hA4);
        rd(3'd5, v); check("R8 abort leaves done clear", v, 32'h0);
        rd(3'd3, v); check("R8 abort and busy read 0", {30'd0, v[7], v[6]}, 32'h0);
        setup(32'hA0, 32'hB0, 32'h50);
        gnt_hold = 1'b1;
        wr(3'd3, cw);
        repeat (4) @(negedge clk);
        wr(3'd4, 32'h0);
        gnt_hold = 1'b0;
        wait_idle();
        rd(3'd0, v); check("R8 deactivate halts after unit", v, 32'hA4);
        rd(3'd5, v); check("R8 deactivate leaves done clear", v, 32'h0);
    endtask

    task automatic t_berr();
        logic [31:0] v;
        int base;
        setup(32'hC0, 32'hCC, 32'h50);
        err_addr = 8'hC4; err_en = 1'b1;
        base = log_n;
        wr(3'd3, M2D | INCM | SWP | (32'd4 << 8) | SW_RUN);
        wait_idle();
        err_en = 1'b0;
        check("R9 stops at failing access", 32'(log_n - base), 32'd3);
        rd(3'd5, v); check("R9 bus error flag only", v, 32'h1);
        rd(3'd0, v); check("R9 no advance for failed unit", v, 32'hC4);
        rd(3'd3, v); check("R9 busy dropped", {31'd0, v[7]}, 32'h0);
    endtask

    task automatic t_w1c_irq();
        logic [31:0] v;
        @(negedge clk);
        check("R11 irq low with no enable", {31'd0, irq}, 32'h0);
        wr(3'd6, 32'h1);
        #1; check("R11 irq with enabled flag", {31'd0, irq}, 32'h1);
        wr(3'd5, 32'h0);
        rd(3'd5, v); check("R10 write 0 keeps flag", v, 32'h1);
        wr(3'd5, 32'h1);
        rd(3'd5, v); check("R10 write 1 clears flag", v, 32'h0);
        #1; check("R11 irq drops after clear", {31'd0, irq}, 32'h0);
        // leave done set, then collide a clear with a new done
        setup(32'hD0, 32'hD0, 32'h50);
        wr(3'd3, M2D | INCM | SWP | (32'd4 << 8) | SW_RUN);
        wait_idle();
        setup(32'hD0, 32'hD4, 32'h50);
        hold_wr = 1'b1;
        wr(3'd3, M2D | INCM | SWP | (32'd4 << 8) | SW_RUN);
        repeat (8) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'hF; hold_wr = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        rd(3'd5, v); check("R10 set wins over same-cycle clear", v, 32'h4);
        wr(3'd6, 32'h4);
        #1; check("R11 irq from done", {31'd0, irq}, 32'h1);
        wr(3'd5, 32'h4);
        #1; check("R11 irq cleared", {31'd0, irq}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_m2d();
        t_d2m();
        t_size_default();
        t_empty();
        t_hw();
        t_ovf();
        t_abort();
        t_berr();
        t_w1c_irq();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule